// File: doc/BRIEF.md
# Clock Output Select and Divide Controller

This block fans four output clocks, named path 0 to path 3, out of four candidate sources. The sources are one reference clock and three clocks from on-chip PLLs. Each path has its own source selector and its own integer post divider, and the divider is clocked by the source that path has selected. Paths 2 and 3 each hold two full settings (source and modulus). A live pin, `bank_sel`, picks one of the two at any time, so software never has to rewrite them. Switching a running path from one bank to the other may glitch that output; the design accepts this.

Software loads the whole configuration word through a one-bit serial stream, most significant bit first, using a valid/ready handshake in the `ref_clk` domain. A bit is taken on a rising edge of `ref_clk` where `cfg_valid` and `cfg_ready` are both high. The sender must hold `cfg_valid` and `cfg_bit` steady while `cfg_ready` is low. After the last bit of a word, `cfg_ready` drops for exactly one cycle and the new word is committed in that cycle. Two pins act globally. `pwr_dn` stops only the paths whose enable bit is set, and `out_en` tri-states every output.

Configuration word, CFG_W = 4 + 6*(2+DIV_W) bits (52 with DIV_W = 6). Bits [3:0] are the power-down enable bits, bit i for path i. The six banks sit at bit 4 + k*(2+DIV_W), with k=0 for path 0, k=1 for path 1, k=2/3 for path 2 bank 0/1, and k=4/5 for path 3 bank 0/1. Each bank is {src[1:0], div[DIV_W-1:0]}, with src in the upper two bits.

Top module: `clk_fanout_divider`

## Requirements
- R1: After reset the whole configuration is zero. Every output then follows `ref_clk` undivided, `cfg_ready` is high and `osc_en` is high.
- R2: The configuration is shifted in MSB first and one bit is accepted per handshake. After the CFG_W-th accepted bit, `cfg_ready` is low for exactly one cycle. The new word takes effect only at the end of that cycle, and the configuration never changes in any other cycle.
- R3: A bank's src field picks the path's source: 0 selects `ref_clk`, 1 selects `pll_clk[0]`, 2 selects `pll_clk[1]` and 3 selects `pll_clk[2]`.
- R4: A modulus of 0 or 1 passes the selected source through undivided.
- R5: A modulus N ≥ 2 gives a period of N source cycles, with (N+1)/2 cycles high and N/2 cycles low (integer division). The high phase starts at counter zero.
- R6: For paths 2 and 3, `bank_sel` low uses bank 0 and high uses bank 1. Paths 0 and 1 ignore `bank_sel`.
- R7: While `pwr_dn` is high, each path whose power-down enable bit is 1 drives its output low. All other paths keep running.
- R8: `osc_en` is low only when `pwr_dn` is high and all four power-down enable bits are 1.
- R9: While `out_en` is low, all four `clk_out` bits are high impedance.
- R10: A new modulus is loaded at the divider's next terminal count, or at once when the path is stopped or passing through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock, also clocks the configuration loader |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_clk | input | 3 | Clocks from the three PLLs |
| cfg_valid | input | 1 | Serial configuration bit is valid |
| cfg_bit | input | 1 | Serial configuration data, MSB first |
| cfg_ready | output | 1 | Loader can accept a bit |
| bank_sel | input | 1 | Bank select for paths 2 and 3 |
| pwr_dn | input | 1 | Global power-down, qualified per path |
| out_en | input | 1 | Output enable; low tri-states all outputs |
| clk_out | output | 4 | Output clocks, bit i is path i |
| osc_en | output | 1 | Low when every path is powered down |

## Verification
A shift register that is off by one bit, or a misplaced field, shows up as the wrong source or the wrong modulus. That error is visible on the first output period measured after the commit cycle. A divider counter or phase register holding a wrong value gives a wrong high or low run length. The bench measures those run lengths in source cycles within a few periods of the selected clock. Bank and power-down faults change whether an output toggles at all, and the bench sees this within one reference cycle of the pin changing.

// File: rtl/cksd_pkg.sv
package cksd_pkg;
  parameter int DIV_W    = 6;
  parameter int NUM_PATH = 4;
  parameter int NUM_BANK = 6;
  parameter int SRC_W    = 2;
  localparam int BANK_W  = SRC_W + DIV_W;
  localparam int CFG_W   = NUM_PATH + NUM_BANK * BANK_W;

  // bank slot used by a path; paths 0/1 own one slot, 2/3 own two
  function automatic int bank_slot(input int path, input int alt);
    if (path < 2) return path;
    return 2 + 2 * (path - 2) + alt;
  endfunction
endpackage

// File: rtl/cksd_cfg_shift.sv
module cksd_cfg_shift #(
  parameter int W = 52
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid,
  input  logic         bit_in,
  output logic         ready,
  output logic [W-1:0] cfg
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] nbits;
  logic          commit;
  logic          take;

  assign ready = !commit;
  assign take  = valid && !commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      nbits  <= '0;
      commit <= 1'b0;
      cfg    <= '0;
    end else if (commit) begin
      cfg    <= shreg;
      commit <= 1'b0;
    end else if (take) begin
      shreg <= {shreg[W-2:0], bit_in};
      if (nbits == CW'(W - 1)) begin
        nbits  <= '0;
        commit <= 1'b1;
      end else begin
        nbits <= nbits + 1'b1;
      end
    end
  end

  // R2: the stall lasts a single cycle
  p_single_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ready);
  // R2: configuration moves only at the end of a stall cycle
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> $stable(cfg));
endmodule

// File: rtl/cksd_post_div.sv
module cksd_post_div #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          clk_o
);
  logic [DW-1:0] n_q;
  logic [DW-1:0] cnt;
  logic [DW-1:0] cnt_nx;
  logic [DW:0]   half;
  logic          q;
  logic          pass;
  logic          term;

  assign pass   = (n_q <= DW'(1));
  assign term   = pass || (cnt >= n_q - DW'(1));
  assign half   = ({1'b0, n_q} + 1'b1) >> 1;
  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      cnt <= '0;
      q   <= 1'b0;
    end else if (!run) begin
      n_q <= div;
      cnt <= div - DW'(1);   // next running edge is a terminal count
      q   <= 1'b0;
    end else if (term) begin
      n_q <= div;
      cnt <= '0;
      q   <= (div > DW'(1));
    end else begin
      cnt <= cnt_nx;
      q   <= ({1'b0, cnt_nx} < half);
    end
  end

  assign clk_o = pass ? (clk & run) : q;

  // R7: a stopped divider holds its phase register low
  p_stop_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !q);
  // R5: counter stays inside the active modulus
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && n_q > DW'(1)) |-> (cnt < n_q));
  // R5: high phase begins only at counter zero
  p_phase_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> (cnt == '0));
endmodule

// File: rtl/cksd_path.sv
module cksd_path #(
  parameter int  DW   = 6,
  parameter int  SW   = 2,
  parameter bit  DUAL = 1'b0
) (
  input  logic             rst_n,
  input  logic [3:0]       srcs,
  input  logic             alt,
  input  logic [SW+DW-1:0] bank_a,
  input  logic [SW+DW-1:0] bank_b,
  input  logic             run,
  output logic             clk_o
);
  localparam int BW = SW + DW;

  logic [BW-1:0] bank;
  logic [SW-1:0] src;
  logic [DW-1:0] div;
  logic          mclk;

  generate
    if (DUAL) begin : g_dual
      assign bank = alt ? bank_b : bank_a;
    end else begin : g_single
      logic unused_in;
      assign unused_in = ^bank_b ^ alt;
      assign bank = bank_a;
    end
  endgenerate

  assign src  = bank[BW-1 -: SW];
  assign div  = bank[DW-1:0];
  assign mclk = srcs[src];

  cksd_post_div #(.DW(DW)) u_div (
    .clk   (mclk),
    .rst_n (rst_n),
    .run   (run),
    .div   (div),
    .clk_o (clk_o)
  );
endmodule

// File: rtl/clk_fanout_divider.sv
module clk_fanout_divider
  import cksd_pkg::*;
(
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic [2:0] pll_clk,
  input  logic       cfg_valid,
  input  logic       cfg_bit,
  output logic       cfg_ready,
  input  logic       bank_sel,
  input  logic       pwr_dn,
  input  logic       out_en,
  output logic [3:0] clk_out,
  output logic       osc_en
);
  logic [CFG_W-1:0]    cfg;
  logic [NUM_PATH-1:0] pd_en;
  logic [NUM_PATH-1:0] run;
  logic [NUM_PATH-1:0] pclk;
  logic [3:0]          srcs;

  assign srcs  = {pll_clk, ref_clk};
  assign pd_en = cfg[NUM_PATH-1:0];

  cksd_cfg_shift #(.W(CFG_W)) u_cfg (
    .clk    (ref_clk),
    .rst_n  (rst_n),
    .valid  (cfg_valid),
    .bit_in (cfg_bit),
    .ready  (cfg_ready),
    .cfg    (cfg)
  );

  generate
    for (genvar i = 0; i < NUM_PATH; i++) begin : g_path
      localparam int LO_A = NUM_PATH + BANK_W * bank_slot(i, 0);
      localparam int LO_B = NUM_PATH + BANK_W * bank_slot(i, 1);
      assign run[i] = !(pwr_dn && pd_en[i]);
      cksd_path #(.DW(DIV_W), .SW(SRC_W), .DUAL(i >= 2)) u_path (
        .rst_n  (rst_n),
        .srcs   (srcs),
        .alt    (bank_sel),
        .bank_a (cfg[LO_A +: BANK_W]),
        .bank_b (cfg[LO_B +: BANK_W]),
        .run    (run[i]),
        .clk_o  (pclk[i])
      );
      assign clk_out[i] = out_en ? pclk[i] : 1'bz;
    end
  endgenerate

  assign osc_en = !(&(~run));

  // R8: without the power-down pin the oscillator stays enabled
  p_osc_on_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !pwr_dn |-> osc_en);
endmodule

// File: tb/clk_fanout_divider_bench.sv
`timescale 1ns/1ps
module clk_fanout_divider_bench;
  import cksd_pkg::*;

  logic       ref_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pll_clk = 3'b000;
  logic       cfg_valid = 1'b0, cfg_bit = 1'b0;
  logic       bank_sel = 1'b0, pwr_dn = 1'b0, out_en = 1'b1;
  wire        cfg_ready, osc_en;
  wire  [3:0] clk_out;

  always #10  ref_clk    = ~ref_clk;   // 50 MHz
  always #7   pll_clk[0] = ~pll_clk[0];
  always #11  pll_clk[1] = ~pll_clk[1];
  always #15  pll_clk[2] = ~pll_clk[2];

  clk_fanout_divider u_clk_fanout_divider (
    .ref_clk(ref_clk), .rst_n(rst_n), .pll_clk(pll_clk),
    .cfg_valid(cfg_valid), .cfg_bit(cfg_bit), .cfg_ready(cfg_ready),
    .bank_sel(bank_sel), .pwr_dn(pwr_dn), .out_en(out_en),
    .clk_out(clk_out), .osc_en(osc_en)
  );

  logic [3:0] srcs;
  int         mi = 0;
  wire        mclk;
  assign srcs = {pll_clk, ref_clk};
  assign mclk = srcs[mi];

  logic [1:0] bsrc[6];
  int         bdiv[6];
  logic [3:0] bpd;
  int tests = 0, fails = 0;

  function automatic logic [CFG_W-1:0] pack_cfg();
    logic [CFG_W-1:0] v = '0;
    v[3:0] = bpd;
    for (int k = 0; k < 6; k++)
      v[4 + k*BANK_W +: BANK_W] = {bsrc[k], DIV_W'(bdiv[k])};
    return v;
  endfunction

  function automatic int exp_hi(int n); return (n + 1) / 2; endfunction
  function automatic int exp_lo(int n); return n / 2; endfunction
  function automatic int slot(int p, bit alt); return bank_slot(p, int'(alt)); endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    bpd = 4'h0;
    for (int k = 0; k < 6; k++) begin bsrc[k] = 2'd0; bdiv[k] = 0; end
  endtask

  task automatic send_cfg();
    logic [CFG_W-1:0] v = pack_cfg();
    @(negedge ref_clk);
    for (int i = CFG_W - 1; i >= 0; i--) begin
      cfg_valid = 1'b1;
      cfg_bit   = v[i];
      while (!cfg_ready) @(negedge ref_clk);
      @(negedge ref_clk);
    end
    cfg_valid = 1'b0;
    chk(cfg_ready == 1'b0, "R2 stall after last bit", int'(cfg_ready), 0);
    @(negedge ref_clk);
    chk(cfg_ready == 1'b1, "R2 stall lasts one cycle", int'(cfg_ready), 1);
  endtask

  // measure path p against source s with modulus n (R3 R4 R5 R10)
  task automatic measure(input int p, input int s, input int n, input string req);
    int hi = 0, lo = 0, guard;
    mi = s;
    repeat (2 * n + 6) @(posedge mclk);
    if (n <= 1) begin
      bit ok = 1'b1;
      repeat (3) begin
        @(posedge mclk); #1;
        if (clk_out[p] !== 1'b1) ok = 1'b0;
        @(negedge mclk); #1;
        if (clk_out[p] !== 1'b0) ok = 1'b0;
      end
      chk(ok, req, int'(ok), 1);
    end else begin
      guard = 0;
      do begin @(posedge mclk); #1; guard++; end while (clk_out[p] !== 1'b0 && guard < 40);
      guard = 0;
      do begin @(posedge mclk); #1; guard++; end while (clk_out[p] !== 1'b1 && guard < 40);
      while (clk_out[p] === 1'b1 && hi < 40) begin hi++; @(posedge mclk); #1; end
      while (clk_out[p] === 1'b0 && lo < 40) begin lo++; @(posedge mclk); #1; end
      chk(hi == exp_hi(n), {req, " high run"}, hi, exp_hi(n));
      chk(lo == exp_lo(n), {req, " low run"}, lo, exp_lo(n));
    end
  endtask

  task automatic check_low(input int p, input string req);
    bit ok = 1'b1;
    repeat (40) begin @(negedge pll_clk[0]); #1; if (clk_out[p] !== 1'b0) ok = 1'b0; end
    chk(ok, req, int'(ok), 1);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    clear_cfg();
    repeat (3) @(negedge ref_clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge ref_clk);
    chk(cfg_ready == 1'b1, "R1 ready after reset", int'(cfg_ready), 1);
    chk(osc_en == 1'b1, "R1 osc_en after reset", int'(osc_en), 1);
    for (int p = 0; p < 4; p++) measure(p, 0, 0, "R1 reset passthrough of ref");

    // R3 R4 R5: every source, pass and odd/even moduli
    bsrc[0] = 2'd1; bdiv[0] = 1;
    bsrc[1] = 2'd2; bdiv[1] = 2;
    bsrc[2] = 2'd3; bdiv[2] = 3;
    bsrc[4] = 2'd0; bdiv[4] = 8;
    send_cfg();
    measure(0, 1, 1, "R4 modulus 1 on pll0");
    measure(1, 2, 2, "R5 div2 on pll1");
    measure(2, 3, 3, "R5 div3 on pll2");
    measure(3, 0, 8, "R3 R5 div8 on ref");

    // R6: banks of paths 2/3; R10 new modulus after reload
    bsrc[3] = 2'd1; bdiv[3] = 5;
    bsrc[5] = 2'd2; bdiv[5] = 0;
    bdiv[0] = 9;
    send_cfg();
    measure(0, 1, 9, "R10 modulus change 1->9");
    bank_sel = 1'b1;
    measure(2, 1, 5, "R6 path2 bank1");
    measure(3, 2, 0, "R6 path3 bank1 modulus 0");
    measure(1, 2, 2, "R6 path1 ignores bank_sel");
    bank_sel = 1'b0;
    measure(2, 3, 3, "R6 path2 bank0");
    measure(3, 0, 8, "R6 path3 bank0");

    // R7 R8: power-down qualified by enable bits
    bpd = 4'b0101;
    send_cfg();
    chk(osc_en == 1'b1, "R8 osc_en with pwr_dn low", int'(osc_en), 1);
    pwr_dn = 1'b1;
    check_low(0, "R7 path0 forced low");
    check_low(2, "R7 path2 forced low");
    measure(1, 2, 2, "R7 path1 keeps running");
    @(negedge ref_clk);
    chk(osc_en == 1'b1, "R8 osc_en with some paths on", int'(osc_en), 1);
    bpd = 4'hF;
    send_cfg();
    @(negedge ref_clk);
    chk(osc_en == 1'b0, "R8 osc_en low all paths down", int'(osc_en), 0);
    check_low(3, "R7 path3 forced low");
    pwr_dn = 1'b0;
    @(negedge ref_clk);
    chk(osc_en == 1'b1, "R8 osc_en back on", int'(osc_en), 1);
    measure(0, 1, 9, "R7 path0 resumes");

    // R9: output enable
    out_en = 1'b0;
    repeat (3) begin
      @(negedge pll_clk[1]); #1;
      for (int p = 0; p < 4; p++)
        chk(clk_out[p] === 1'bz, "R9 tristate", int'(clk_out[p]), 0);
    end
    out_en = 1'b1;

    // random configurations (R2 R3 R5 R6)
    bpd = 4'h0;
    for (int it = 0; it < 6; it++) begin
      for (int k = 0; k < 6; k++) begin
        bsrc[k] = 2'($urandom_range(0, 3));
        bdiv[k] = int'($urandom_range(0, 9));
      end
      bank_sel = 1'($urandom_range(0, 1));
      send_cfg();
      for (int p = 0; p < 4; p++)
        measure(p, int'(bsrc[slot(p, bank_sel)]), bdiv[slot(p, bank_sel)],
                "R2 R3 R5 R6 random config");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule